// File: doc/BRIEF.md
# Extended-Precision ALU Slice

This block is an integer execution slice for multi-word arithmetic and conditional selection. Each accepted operation is computed in one pass of combinational logic and then registered, so results appear one clock after issue. Three operation families are provided. The first is a three-input add whose low sum and carry word go to two separate destinations. The second is a pair of shifts (left and right) that also return, through a second destination, the bits that were shifted out. The third is a set of conditional moves that copy a source into the destination only when a test operand is even, negative, or not greater than zero.

Operands are processed at one of four precisions: 8, 16, 32 bits or the full data width `W`. The precision code sits in the low two bits of the opcode. Only the low bits of each source at that precision are read, and every result written at reduced precision has its upper bits cleared. Because the carry word can be fed back as the third source of the next add, a wide sum is built from a chain of full-width adds whose first carry input is zero.

Opcode layout: `in_op[4:2]` selects the operation (0 add3, 1 shift-left-spill, 2 shift-right-spill, 3 move-if-even, 4 move-if-negative, 5 move-if-not-positive, 6 and 7 reserved). `in_op[1:0]` selects the precision (0 = 8, 1 = 16, 2 = 32, 3 = `W` bits).

Top module: `xpalu_slice`

## Requirements
- R1: While `rst_n` is low at a rising edge, `out_valid`, `we_lo`, `we_hi`, `res_lo` and `res_hi` are all zero after that edge.
- R2: `out_valid` equals `in_valid` from one edge earlier; a cycle issued with `in_valid` low produces `we_lo` and `we_hi` low, whatever the data inputs hold.
- R3: Add3 (code 0) at precision P gives `res_lo` = (a+b+c) mod 2^P and `res_hi` = floor((a+b+c)/2^P), a value from 0 to 2, on the P-bit operands, with both write enables high.
- R4: Four full-width add3 operations, each taking the previous carry word as its third source and the first taking zero, yield a 4W-bit sum plus final carry equal to the wide sum of the two 4W-bit operands.
- R5: Shift-left-spill (code 1) by s < P gives `res_lo` = (a << s) mod 2^P and `res_hi` = the s bits shifted out of the top, right-aligned; both write enables high.
- R6: Shift-right-spill (code 2) by s < P gives `res_lo` = a >> s (logical) and `res_hi` = the s bits shifted out of the bottom, left-aligned at P bits; both write enables high.
- R7: A shift whose amount (`src_b`, unsigned, all W bits) is at least P gives `res_lo` = 0 and `res_hi` = the P-bit operand.
- R8: Move-if-even (code 3) copies the P-bit `src_b` into `res_lo` when bit 0 of `src_a` is 0.
- R9: Move-if-negative (code 4) copies the P-bit `src_b` when bit P-1 of `src_a` is 1.
- R10: Move-if-not-positive (code 5) copies the P-bit `src_b` when bit P-1 of `src_a` is 1 or the low P bits of `src_a` are all zero.
- R11: A conditional move with a false condition returns the full unmasked `old_dst` in `res_lo`; every conditional move gives `we_lo` high and `we_hi` low.
- R12: At reduced precision, bits of `res_lo` and `res_hi` at and above P are zero, and source bits above P do not affect any result.
- R13: Reserved operation codes 6 and 7 give both write enables low and both results zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operation issued this cycle |
| in_op | input | 5 | Operation code [4:2] and precision code [1:0] |
| src_a | input | W | First operand; shift operand; condition test operand |
| src_b | input | W | Second operand; shift amount; move value |
| src_c | input | W | Third add operand (carry in) |
| old_dst | input | W | Present value of the first destination |
| out_valid | output | 1 | Results valid |
| res_lo | output | W | Primary result |
| res_hi | output | W | Second result (carry word or spilled bits) |
| we_lo | output | 1 | Write enable for the primary destination |
| we_hi | output | 1 | Write enable for the second destination |

## Verification
The primary and second destination are written in the same cycle by add3 and both shifts, while a conditional move in the next cycle must drop the second enable and a reserved or idle slot must drop both. The bench provokes this by issuing operations back to back with no gaps, alternating two-result operations with moves, reserved codes and idle slots carrying garbage data. Each cycle a scoreboard compares both results and both enables against a model computed in the bench, and the chained wide add is judged once more as a whole against a 256-bit sum.

// File: rtl/xpalu_pkg.sv
// Shared operation codes for the extended-precision ALU slice.
// Assumes the opcode carries the operation in bits [4:2] and the
// precision in bits [1:0].
package xpalu_pkg;
    localparam logic [2:0] OPK_ADD3   = 3'd0;
    localparam logic [2:0] OPK_SHL2   = 3'd1;
    localparam logic [2:0] OPK_SHR2   = 3'd2;
    localparam logic [2:0] OPK_MVEVN  = 3'd3;
    localparam logic [2:0] OPK_MVNEG  = 3'd4;
    localparam logic [2:0] OPK_MVNPOS = 3'd5;

    localparam logic [1:0] PREC_8    = 2'd0;
    localparam logic [1:0] PREC_16   = 2'd1;
    localparam logic [1:0] PREC_32   = 2'd2;
    localparam logic [1:0] PREC_FULL = 2'd3;
endpackage

// File: rtl/xpalu_prec.sv
// Precision decoder: turns the 2-bit precision code into a bit count,
// a low-bit mask, the masked operand and its sign bit.
// Assumes W is greater than 32.
module xpalu_prec #(
    parameter int W  = 64,
    localparam int PW = $clog2(W) + 1
) (
    input  logic [1:0]    prec,
    input  logic [W-1:0]  opnd,
    output logic [PW-1:0] pbits,
    output logic [W-1:0]  mask,
    output logic [W-1:0]  opnd_m,
    output logic          sign_bit
);
    import xpalu_pkg::*;

    // Decode width, mask and sign position for the chosen precision.
    always_comb begin
        case (prec)
            PREC_8: begin
                pbits    = PW'(8);
                mask     = W'(8'hFF);
                sign_bit = opnd[7];
            end
            PREC_16: begin
                pbits    = PW'(16);
                mask     = W'(16'hFFFF);
                sign_bit = opnd[15];
            end
            PREC_32: begin
                pbits    = PW'(32);
                mask     = W'(32'hFFFF_FFFF);
                sign_bit = opnd[31];
            end
            default: begin
                pbits    = PW'(W);
                mask     = '1;
                sign_bit = opnd[W-1];
            end
        endcase
        opnd_m = opnd & mask;
    end
endmodule

// File: rtl/xpalu_adder3.sv
// Three-input adder at a selectable precision. Returns the low P bits
// of the sum and the carry word (0..2) above them.
// Assumes inputs are already masked to P bits.
module xpalu_adder3 #(
    parameter int W  = 64,
    localparam int PW = $clog2(W) + 1
) (
    input  logic [W-1:0]  a_m,
    input  logic [W-1:0]  b_m,
    input  logic [W-1:0]  c_m,
    input  logic [PW-1:0] pbits,
    input  logic [W-1:0]  mask,
    output logic [W-1:0]  sum_lo,
    output logic [W-1:0]  sum_hi
);
    logic [W+1:0] total;

    // Form the wide sum and split it at the precision boundary.
    always_comb begin
        total  = {2'b00, a_m} + {2'b00, b_m} + {2'b00, c_m};
        sum_lo = total[W-1:0] & mask;
        sum_hi = W'(total >> pbits);
    end
endmodule

// File: rtl/xpalu_funnel.sv
// Double-width funnel shifter. Left: {spill, main} = {0, a} << s.
// Right: {main, spill} = {a, 0} >> s, both at P bits. Shift amounts
// at or above P are clamped to P. Assumes the operand is masked.
module xpalu_funnel #(
    parameter int W  = 64,
    localparam int PW = $clog2(W) + 1
) (
    input  logic [W-1:0]  a_m,
    input  logic [W-1:0]  amt,
    input  logic [PW-1:0] pbits,
    input  logic [W-1:0]  mask,
    input  logic          go_right,
    output logic [W-1:0]  main_out,
    output logic [W-1:0]  spill_out
);
    logic [PW-1:0]  s_eff;
    logic [2*W-1:0] wide_l;
    logic [2*W-1:0] wide_r;

    // Clamp the amount, then shift the operand inside a 2W field.
    always_comb begin
        s_eff  = (amt >= W'(pbits)) ? pbits : amt[PW-1:0];
        wide_l = {{W{1'b0}}, a_m} << s_eff;
        wide_r = ({{W{1'b0}}, a_m} << pbits) >> s_eff;
        if (go_right) begin
            main_out  = W'(wide_r >> pbits) & mask;
            spill_out = wide_r[W-1:0] & mask;
        end else begin
            main_out  = wide_l[W-1:0] & mask;
            spill_out = W'(wide_l >> pbits) & mask;
        end
    end
endmodule

// File: rtl/xpalu_slice.sv
// Extended-precision ALU slice: three-input add with carry word,
// shifts with spill result, conditional moves. One register stage
// between issue and result. Synchronous active-low reset.
module xpalu_slice #(
    parameter int W = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic [4:0]   in_op,
    input  logic [W-1:0] src_a,
    input  logic [W-1:0] src_b,
    input  logic [W-1:0] src_c,
    input  logic [W-1:0] old_dst,
    output logic         out_valid,
    output logic [W-1:0] res_lo,
    output logic [W-1:0] res_hi,
    output logic         we_lo,
    output logic         we_hi
);
    import xpalu_pkg::*;
    localparam int PW = $clog2(W) + 1;

    logic [2:0]    opk;
    logic [PW-1:0] pbits;
    logic [W-1:0]  mask, a_m, b_m, c_m;
    logic          a_sign;
    logic [W-1:0]  add_lo, add_hi, sh_main, sh_spill;
    logic          cond;
    logic [W-1:0]  nxt_lo, nxt_hi;
    logic          nxt_wl, nxt_wh;

    assign opk = in_op[4:2];

    xpalu_prec #(.W(W)) u_prec (
        .prec(in_op[1:0]), .opnd(src_a), .pbits(pbits),
        .mask(mask), .opnd_m(a_m), .sign_bit(a_sign)
    );

    // Restrict the other sources to the chosen precision.
    always_comb begin
        b_m = src_b & mask;
        c_m = src_c & mask;
    end

    xpalu_adder3 #(.W(W)) u_add (
        .a_m(a_m), .b_m(b_m), .c_m(c_m), .pbits(pbits), .mask(mask),
        .sum_lo(add_lo), .sum_hi(add_hi)
    );

    xpalu_funnel #(.W(W)) u_shf (
        .a_m(a_m), .amt(src_b), .pbits(pbits), .mask(mask),
        .go_right(opk == OPK_SHR2),
        .main_out(sh_main), .spill_out(sh_spill)
    );

    // Evaluate the move condition on the test operand at precision.
    always_comb begin
        case (opk)
            OPK_MVEVN:  cond = ~a_m[0];
            OPK_MVNEG:  cond = a_sign;
            OPK_MVNPOS: cond = a_sign | (a_m == '0);
            default:    cond = 1'b0;
        endcase
    end

    // Select results and destination enables by operation.
    always_comb begin
        nxt_lo = '0;
        nxt_hi = '0;
        nxt_wl = 1'b0;
        nxt_wh = 1'b0;
        case (opk)
            OPK_ADD3: begin
                nxt_lo = add_lo;
                nxt_hi = add_hi;
                nxt_wl = 1'b1;
                nxt_wh = 1'b1;
            end
            OPK_SHL2, OPK_SHR2: begin
                nxt_lo = sh_main;
                nxt_hi = sh_spill;
                nxt_wl = 1'b1;
                nxt_wh = 1'b1;
            end
            OPK_MVEVN, OPK_MVNEG, OPK_MVNPOS: begin
                nxt_lo = cond ? b_m : old_dst;
                nxt_wl = 1'b1;
            end
            default: ;
        endcase
    end

    // Result register; enables drop on idle cycles, data holds.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            res_lo    <= '0;
            res_hi    <= '0;
            we_lo     <= 1'b0;
            we_hi     <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                res_lo <= nxt_lo;
                res_hi <= nxt_hi;
                we_lo  <= nxt_wl;
                we_hi  <= nxt_wh;
            end else begin
                we_lo  <= 1'b0;
                we_hi  <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/xpalu_slice_chk.sv
// Property checker for xpalu_slice, attached by bind below.
// Assumes it observes the top-level ports only.
module xpalu_slice_chk #(
    parameter int W = 64
) (
    input logic         clk,
    input logic         rst_n,
    input logic         in_valid,
    input logic [4:0]   in_op,
    input logic [W-1:0] src_a,
    input logic [W-1:0] src_b,
    input logic [W-1:0] src_c,
    input logic [W-1:0] old_dst,
    input logic         out_valid,
    input logic [W-1:0] res_lo,
    input logic [W-1:0] res_hi,
    input logic         we_lo,
    input logic         we_hi
);
    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && !we_lo && !we_hi && res_lo == '0 && res_hi == '0));

    a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    a_r2_idle_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && !we_lo && !we_hi));

    a_r3_carry_small: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op[4:2] == 3'd0) |=> (we_lo && we_hi && res_hi <= W'(2)));

    a_r7_shift_saturate: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (in_op[4:2] == 3'd1 || in_op[4:2] == 3'd2) && in_op[1:0] == 2'd3
         && src_b >= W'(W)) |=> (res_lo == '0 && res_hi == $past(src_a)));

    a_r11_move_one_dest: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op[4:2] >= 3'd3 && in_op[4:2] <= 3'd5) |=> (we_lo && !we_hi));

    a_r12_byte_upper_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op[1:0] == 2'd0 && in_op[4:2] <= 3'd2)
        |=> (res_lo[W-1:8] == '0 && res_hi[W-1:8] == '0));

    a_r13_reserved_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op[4:3] == 2'b11) |=> (!we_lo && !we_hi && res_lo == '0 && res_hi == '0));
endmodule

bind xpalu_slice xpalu_slice_chk #(.W(W)) u_chk (.*);

// File: tb/xpalu_slice_test.sv
// Scoreboard bench for xpalu_slice: driver pushes modelled results,
// monitor pops and compares one cycle after issue.
module xpalu_slice_test;
    localparam int W = 64;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [4:0]   in_op = '0;
    logic [W-1:0] src_a = '0, src_b = '0, src_c = '0, old_dst = '0;
    logic         out_valid, we_lo, we_hi;
    logic [W-1:0] res_lo, res_hi;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 0;

    typedef struct {
        bit          v;
        logic [63:0] lo;
        logic [63:0] hi;
        bit          wl;
        bit          wh;
        string       req;
        int          stamp;
        int          slot;
    } item_t;

    item_t sb[$];
    logic [63:0] chain_lo[4];
    logic [63:0] chain_hi[4];

    xpalu_slice #(.W(W)) uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
        .src_a(src_a), .src_b(src_b), .src_c(src_c), .old_dst(old_dst),
        .out_valid(out_valid), .res_lo(res_lo), .res_hi(res_hi),
        .we_lo(we_lo), .we_hi(we_hi)
    );

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic item_t model(logic [4:0] op, logic [63:0] a, logic [63:0] b,
                                    logic [63:0] c, logic [63:0] o);
        item_t it;
        int p;
        logic [63:0] m, am, bm, cm;
        logic [65:0] s;
        bit cnd;
        p  = (op[1:0] == 2'd0) ? 8 : (op[1:0] == 2'd1) ? 16 : (op[1:0] == 2'd2) ? 32 : 64;
        m  = (p == 64) ? '1 : ((64'd1 << p) - 64'd1);
        am = a & m; bm = b & m; cm = c & m;
        it.v = 1; it.lo = '0; it.hi = '0; it.wl = 0; it.wh = 0; it.slot = -1;
        case (op[4:2])
            3'd0: begin
                s = {2'b00, am} + {2'b00, bm} + {2'b00, cm};
                it.lo = s[63:0] & m;
                it.hi = 64'(s >> p);
                it.wl = 1; it.wh = 1;
            end
            3'd1: begin
                it.wl = 1; it.wh = 1;
                if (b >= 64'(p)) begin it.lo = '0; it.hi = am; end
                else begin
                    it.lo = (am << b) & m;
                    it.hi = (b == 0) ? '0 : (am >> (64'(p) - b));
                end
            end
            3'd2: begin
                it.wl = 1; it.wh = 1;
                if (b >= 64'(p)) begin it.lo = '0; it.hi = am; end
                else begin
                    it.lo = am >> b;
                    it.hi = (b == 0) ? '0 : ((am << (64'(p) - b)) & m);
                end
            end
            3'd3, 3'd4, 3'd5: begin
                if (op[4:2] == 3'd3)      cnd = (am[0] == 1'b0);
                else if (op[4:2] == 3'd4) cnd = am[p-1];
                else                      cnd = am[p-1] || (am == 0);
                it.lo = cnd ? bm : o;
                it.wl = 1;
            end
            default: ;
        endcase
        return it;
    endfunction

    task automatic drive(input logic [4:0] op, input logic [63:0] a, input logic [63:0] b,
                         input logic [63:0] c, input logic [63:0] o, input string req,
                         input int slot = -1);
        item_t it;
        @(negedge clk);
        in_valid = 1; in_op = op; src_a = a; src_b = b; src_c = c; old_dst = o;
        it = model(op, a, b, c, o);
        it.req = req; it.stamp = cyc; it.slot = slot;
        sb.push_back(it);
    endtask

    task automatic idle(input string req);
        item_t it;
        @(negedge clk);
        in_valid = 0; in_op = 5'b00000;
        src_a = 64'hDEAD_BEEF_0BAD_F00D; src_b = 64'h1; src_c = 64'h2; old_dst = 64'h3;
        it.v = 0; it.lo = '0; it.hi = '0; it.wl = 0; it.wh = 0;
        it.req = req; it.stamp = cyc; it.slot = -1;
        sb.push_back(it);
    endtask

    // Monitor: compare each due scoreboard item against the ports.
    always @(negedge clk) begin
        if (rst_n) begin
            if (sb.size() > 0 && sb[0].stamp < cyc) begin
                item_t e;
                e = sb.pop_front();
                checks++;
                if (e.v) begin
                    if (e.slot >= 0) begin
                        chain_lo[e.slot] = res_lo;
                        chain_hi[e.slot] = res_hi;
                    end
                    if (!out_valid || res_lo !== e.lo || res_hi !== e.hi
                        || we_lo !== e.wl || we_hi !== e.wh) begin
                        errors++;
                        $display("FAIL %s: got v=%0b lo=%h hi=%h wl=%0b wh=%0b exp v=1 lo=%h hi=%h wl=%0b wh=%0b",
                                 e.req, out_valid, res_lo, res_hi, we_lo, we_hi,
                                 e.lo, e.hi, e.wl, e.wh);
                    end
                end else if (out_valid || we_lo || we_hi) begin
                    errors++;
                    $display("FAIL %s: got v=%0b wl=%0b wh=%0b exp v=0 wl=0 wh=0",
                             e.req, out_valid, we_lo, we_hi);
                end
            end else if (out_valid) begin
                checks++;
                errors++;
                $display("FAIL R2: got out_valid=1 exp 0 (nothing issued)");
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(4 * 20000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout exp completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [255:0] wa, wb;
        logic [256:0] wsum, wgot;
        item_t pr;
        logic [63:0] cy;

        // R1: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        checks++;
        if (out_valid || we_lo || we_hi || res_lo !== '0 || res_hi !== '0) begin
            errors++;
            $display("FAIL R1: got v=%0b wl=%0b wh=%0b lo=%h hi=%h exp all zero",
                     out_valid, we_lo, we_hi, res_lo, res_hi);
        end
        rst_n = 1;

        // R3: full-width add with maximal carry
        drive(5'b000_11, '1, '1, '1, '0, "R3 add3 full max");
        // R3/R12: byte add, upper source bits ignored
        drive(5'b000_00, 64'h12F0, 64'hFF00_0080, 64'hAB01, '0, "R3 R12 add3 byte");
        drive(5'b000_10, 64'hFFFF_FFFF_8000_0000, 64'h8000_0000, 64'h5, '0, "R3 R12 add3 word32");
        // R5: left shifts
        drive(5'b001_11, 64'hF000_0000_0000_0001, 64'd4, '0, '0, "R5 shl full");
        drive(5'b001_01, 64'hABCD_1234, 64'd4, '0, '0, "R5 R12 shl half");
        drive(5'b001_11, 64'h0123_4567_89AB_CDEF, 64'd0, '0, '0, "R5 shl by zero");
        // R6: right shifts
        drive(5'b010_10, 64'h1234_5678_9ABC_DEF0, 64'd8, '0, '0, "R6 R12 shr word32");
        drive(5'b010_11, 64'h8000_0000_0000_00FF, 64'd63, '0, '0, "R6 shr full 63");
        // R7: saturating amounts
        drive(5'b001_11, 64'hCAFE_F00D_1234_5678, 64'd64, '0, '0, "R7 shl full 64");
        drive(5'b010_00, 64'hFFA5, 64'd200, '0, '0, "R7 shr byte 200");
        drive(5'b001_00, 64'h3C, 64'd8, '0, '0, "R7 shl byte 8");
        drive(5'b010_11, 64'h55, 64'h8000_0000_0000_0000, '0, '0, "R7 shr huge amount");
        // R8..R11: conditional moves, true and false
        drive(5'b011_11, 64'h10, 64'hAAAA_BBBB_CCCC_DDDD, '0, 64'h1111, "R8 mv even true");
        drive(5'b011_11, 64'h11, 64'hAAAA_BBBB_CCCC_DDDD, '0, 64'h7777_8888_9999_0000, "R11 mv even false");
        drive(5'b100_01, 64'h8000, 64'hFFFF_1234, '0, 64'h42, "R9 R12 mv neg half true");
        drive(5'b100_01, 64'h1_7FFF, 64'hFFFF_1234, '0, 64'hFEDC_BA98_7654_3210, "R9 R11 mv neg half false");
        drive(5'b101_00, 64'hFF00, 64'h1_99, '0, 64'h9, "R10 mv npos byte zero");
        drive(5'b101_10, 64'h8000_0001, 64'h77, '0, 64'h9, "R10 mv npos word neg");
        drive(5'b101_11, 64'h1, 64'h77, '0, 64'h0123_0000_0000_4567, "R10 R11 mv npos false");
        // R13: reserved codes interleaved with two-result ops
        drive(5'b110_11, '1, '1, '1, '1, "R13 reserved 6");
        drive(5'b000_11, 64'h1, '1, 64'h0, '0, "R3 add3 after reserved");
        drive(5'b111_00, '1, '1, '1, '1, "R13 reserved 7");
        // R2: idle slot with garbage data, then back to work
        idle("R2 idle slot");
        drive(5'b011_00, 64'h2, 64'h1FF, '0, 64'h5, "R8 R12 mv even byte");
        idle("R2 idle slot 2");

        // R4: 256-bit add as four chained full-width adds
        wa = {64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0001,
              64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFE};
        wb = {64'h8000_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FFFF,
              64'h0000_0000_0000_0000, 64'h0000_0000_0000_0003};
        cy = '0;
        for (int k = 0; k < 4; k++) begin
            drive(5'b000_11, wa[k*64 +: 64], wb[k*64 +: 64], cy, '0, "R4 chain step", k);
            pr = model(5'b000_11, wa[k*64 +: 64], wb[k*64 +: 64], cy, '0);
            cy = pr.hi;
        end
        idle("R2 idle tail");
        repeat (3) @(negedge clk);

        wsum = {1'b0, wa} + {1'b0, wb};
        wgot = {chain_hi[3][0], chain_lo[3], chain_lo[2], chain_lo[1], chain_lo[0]};
        checks++;
        if (wgot !== wsum) begin
            errors++;
            $display("FAIL R4: got %h exp %h", wgot, wsum);
        end

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule